// File: doc/BRIEF.md
# Four-Bank Interleaved Byte Memory Controller

This block is a byte-wide memory made of four separate banks that are modelled internally as arrays. A requester presents one access per clock on a valid/ready request port. Each access carries a byte address, a read/write flag and write data. The controller splits the address into a bank index and an offset within the bank, then starts the access in that bank.

Each bank stays occupied for a fixed number of clocks after it takes an access. Accesses to different banks therefore overlap. With the default low-order mapping, a unit-stride stream moves one byte per clock, even though every bank is occupied for several clocks per access. A stride equal to the bank count keeps hitting the same bank, so it runs at one byte per bank occupancy period. A compile-time parameter switches to block mapping for comparison; in that mode each bank owns one contiguous quarter of the address space.

Read data comes out on a response port a fixed number of clocks after acceptance, in the order the reads were accepted. The response port has a valid strobe and no ready. The requester must take every beat in the clock it appears.

Back-pressure follows these rules:
- The request port accepts an access in any cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is low exactly when the addressed bank is still occupied.
- The requester keeps the request steady until it is accepted. No later request can pass a stalled one.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, `rsp_valid` is low, and `req_ready` is high for every address because all banks start idle.
- R2: With `INTERLEAVE`=1 (default), byte address A uses bank A mod 4 at offset A div 4. Addresses 1 and 5 share a bank; addresses 1 and 2 do not.
- R3: With `INTERLEAVE`=0, byte address A uses bank A div 256 at offset A mod 256. Addresses 0..15 all share bank 0; addresses 0, 256, 512 and 768 use four different banks.
- R4: After a bank accepts an access, it accepts its next access no earlier than `CYCLE` clocks later (default 4). While it is occupied, a request to it sees `req_ready` low.
- R5: Requests to different idle banks are accepted on consecutive clocks. A unit-stride stream in interleaved mode is accepted at one per clock.
- R6: A read accepted at a clock edge produces exactly one beat with `rsp_valid` high. That beat appears `LAT` clocks later (default 2; visible after edge k+LAT-1 when accepted at edge k). It carries the byte most recently written to that address.
- R7: A write occupies its bank exactly like a read, updates the addressed byte, and produces no response beat.
- R8: Responses leave in acceptance order. A request stalled on a busy bank blocks all later requests, so a later access is never ordered ahead of an earlier one, including a read after a write to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can take the request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data beat present (no back-pressure) |
| rsp_data | output | 8 | Read data |

## Verification
Two functions can fall in the same cycle: a new request is accepted or stalled, and an older read's data leaves the response pipe. Mixed read/write sequences with repeated bank hits provoke this. In those sequences, stalls on a busy bank coincide with beats draining from earlier reads, and writes are accepted while a read beat is leaving. Every beat is judged against a reference copy of memory, on both the data and the exact clock it appears. Any extra beat, missing beat or reordered beat is reported, and so is the acceptance spacing of each stream.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
  parameter int NBANK      = 4,
  parameter int BANK_BYTES = 256,
  parameter bit INTERLEAVE = 1'b1,
  localparam int BK_W   = $clog2(NBANK),
  localparam int OFF_W  = $clog2(BANK_BYTES),
  localparam int ADDR_W = BK_W + OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BK_W-1:0]   bank,
  output logic [OFF_W-1:0]  off
);
  // Both counts must be powers of two; the split is a pure bit slice.
  generate
    if (INTERLEAVE) begin : g_low
      assign bank = addr[BK_W-1:0];
      assign off  = addr[ADDR_W-1:BK_W];
    end else begin : g_high
      assign bank = addr[ADDR_W-1:OFF_W];
      assign off  = addr[OFF_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CYCLE = 4,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(CYCLE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             we,
  input  logic [OFF_W-1:0] off,
  input  byte_t            wdata,
  output logic             free,
  output byte_t            rdata
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (take && we) mem[off] <= wdata;
  end

  assign rdata = mem[off];

  generate
    if (CYCLE > 1) begin : g_occ
      logic [CNT_W-1:0] left_q;
      always_ff @(posedge clk) begin
        if (!rst_n)               left_q <= '0;
        else if (take)            left_q <= CNT_W'(CYCLE - 1);
        else if (left_q != '0)    left_q <= left_q - 1'b1;
      end
      assign free = (left_q == '0);
    end else begin : g_nocc
      assign free = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ilv_rsp_pipe.sv
module ilv_rsp_pipe
  import ilv_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_vld,
  input  byte_t in_data,
  output logic  out_vld,
  output byte_t out_data
);
  logic  vld_q  [LAT];
  byte_t data_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q[0] <= 1'b0;
    else        vld_q[0] <= in_vld;
    data_q[0] <= in_data;
  end

  generate
    for (genvar s = 1; s < LAT; s++) begin : g_stg
      always_ff @(posedge clk) begin
        if (!rst_n) vld_q[s] <= 1'b0;
        else        vld_q[s] <= vld_q[s-1];
        data_q[s] <= data_q[s-1];
      end
    end
  endgenerate

  assign out_vld  = vld_q[LAT-1];
  assign out_data = data_q[LAT-1];
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
  import ilv_pkg::*;
#(
  parameter int NBANK      = 4,
  parameter int BANK_BYTES = 256,
  parameter int CYCLE      = 4,
  parameter int LAT        = 2,
  parameter bit INTERLEAVE = 1'b1,
  localparam int BK_W   = $clog2(NBANK),
  localparam int OFF_W  = $clog2(BANK_BYTES),
  localparam int ADDR_W = BK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data
);
  logic [BK_W-1:0]  bank;
  logic [OFF_W-1:0] off;
  logic [NBANK-1:0] bank_free;
  byte_t            bank_rdata [NBANK];
  logic             accept;

  ilv_addr_map #(
    .NBANK(NBANK), .BANK_BYTES(BANK_BYTES), .INTERLEAVE(INTERLEAVE)
  ) u_map (
    .addr(req_addr), .bank(bank), .off(off)
  );

  // Ready looks only at the bank this request targets.
  assign req_ready = bank_free[bank];
  assign accept    = req_valid && req_ready;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      ilv_bank #(.DEPTH(BANK_BYTES), .CYCLE(CYCLE)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (accept && (bank == BK_W'(b))),
        .we    (req_write),
        .off   (off),
        .wdata (req_wdata),
        .free  (bank_free[b]),
        .rdata (bank_rdata[b])
      );
    end
  endgenerate

  ilv_rsp_pipe #(.LAT(LAT)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (accept && !req_write),
    .in_data  (bank_rdata[bank]),
    .out_vld  (rsp_valid),
    .out_data (rsp_data)
  );
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk #(
  parameter int NBANK      = 4,
  parameter int BANK_BYTES = 256,
  parameter int CYCLE      = 4,
  parameter int LAT        = 2,
  parameter bit INTERLEAVE = 1'b1,
  localparam int BK_W   = $clog2(NBANK),
  localparam int OFF_W  = $clog2(BANK_BYTES),
  localparam int ADDR_W = BK_W + OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [7:0]        rsp_data
);
  logic [BK_W-1:0] tgt;
  logic            acc;
  logic [7:0]      pend_q;

  assign tgt = INTERLEAVE ? req_addr[BK_W-1:0] : req_addr[ADDR_W-1:OFF_W];
  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_q + 8'(acc && !req_write) - 8'(rsp_valid);
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsp_valid);

  a_r4_bank_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (CYCLE > 1)) |=> !(req_valid && req_ready && (tgt == $past(tgt))));

  a_r7_no_write_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (pend_q != 8'd0));

  a_r6_bounded_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= 8'(LAT));

  a_r6_data_known: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$isunknown(rsp_data));

  a_r8_ready_known: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !$isunknown(req_ready));
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
  .NBANK(NBANK), .BANK_BYTES(BANK_BYTES), .CYCLE(CYCLE),
  .LAT(LAT), .INTERLEAVE(INTERLEAVE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data)
);

// File: tb/sim_ilv_mem_ctrl.sv
module sim_ilv_mem_ctrl;
  localparam int PER = 10;
  localparam int LAT = 2;
  localparam int CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rdy0, rdy1, rv0, rv1;
  logic [7:0] rd0, rd1;
  int cyc = 0;
  int n_chk = 0, n_fail = 0;

  logic [7:0] ref_mem [2][1024];
  logic [7:0] exp_data [4096];
  int exp_cyc [4096];
  int wr_p = 0, rd_p = 0;

  always #(PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_mem_ctrl #(.CYCLE(CYC), .LAT(LAT), .INTERLEAVE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !sel), .req_ready(rdy0),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv0), .rsp_data(rd0));

  ilv_mem_ctrl #(.CYCLE(CYC), .LAT(LAT), .INTERLEAVE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && sel), .req_ready(rdy1),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv1), .rsp_data(rd1));

  wire       rdy = sel ? rdy1 : rdy0;
  wire       rv  = sel ? rv1 : rv0;
  wire [7:0] rdt = sel ? rd1 : rd0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Response monitor: order, data and exact beat clock.
  always @(negedge clk) begin
    if (rst_n) begin
      if ((sel && rv0) || (!sel && rv1)) chk(1'b0, "R8 beat from idle unit", 1, 0);
      if (rv) begin
        if (rd_p == wr_p) chk(1'b0, "R7 unexpected beat", 1, 0);
        else begin
          chk(rdt == exp_data[rd_p], "R6/R8 read data", int'(rdt), int'(exp_data[rd_p]));
          chk(cyc == exp_cyc[rd_p], "R6 beat clock", cyc, exp_cyc[rd_p]);
          rd_p++;
        end
      end else if (rd_p != wr_p && exp_cyc[rd_p] <= cyc) begin
        chk(1'b0, "R6 missing beat", cyc, exp_cyc[rd_p]);
        rd_p++;
      end
    end
  end

  // Called at a falling edge; returns the rising-edge index of acceptance.
  task automatic issue(input logic w, input logic [9:0] a, input logic [7:0] d,
                       output int acc);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!rdy) begin @(negedge clk); #1; end
    acc = cyc + 1;
    if (w) ref_mem[sel][a] = d;
    else begin
      exp_data[wr_p] = ref_mem[sel][a];
      exp_cyc[wr_p]  = acc + LAT - 1;
      wr_p++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (LAT + CYC + 2) @(negedge clk);
    chk(rd_p == wr_p, "R6 all read beats returned", rd_p, wr_p);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 13 + (a >> 8) + 8'h5A);
  endfunction

  task automatic t_reset();
    #1;
    chk(rdy0 == 1'b1, "R1 ready after reset (interleaved)", int'(rdy0), 1);
    chk(rdy1 == 1'b1, "R1 ready after reset (block)", int'(rdy1), 1);
    chk(rv0 == 1'b0 && rv1 == 1'b0, "R1 no beat after reset", int'(rv0 | rv1), 0);
  endtask

  task automatic t_fill_interleaved();
    int first = 0, last = 0;
    sel = 1'b0;
    for (int a = 0; a < 1024; a++) begin
      issue(1'b1, 10'(a), pat(a), last);
      if (a == 0) first = last;
    end
    chk(last - first == 1023, "R5/R7 unit-stride writes one per clock", last - first, 1023);
    settle();
  endtask

  task automatic t_stream(input int stride, input int n, input int gap, input string rq);
    int first = 0, last = 0;
    for (int i = 0; i < n; i++) begin
      issue(1'b0, 10'((i * stride) % 1024), 8'h00, last);
      if (i == 0) first = last;
    end
    chk(last - first == (n - 1) * gap, rq, last - first, (n - 1) * gap);
    settle();
  endtask

  task automatic t_pairs();
    int x = 0, y = 0;
    sel = 1'b0;
    issue(1'b0, 10'd1, 8'h00, x);
    issue(1'b0, 10'd5, 8'h00, y);
    chk(y - x == CYC, "R2/R4 addresses 1 and 5 share a bank", y - x, CYC);
    settle();
    issue(1'b0, 10'd1, 8'h00, x);
    issue(1'b0, 10'd2, 8'h00, y);
    chk(y - x == 1, "R2/R5 addresses 1 and 2 in different banks", y - x, 1);
    settle();
  endtask

  task automatic t_block();
    int first = 0, last = 0;
    sel = 1'b1;
    for (int o = 0; o < 256; o++)
      for (int b = 0; b < 4; b++) begin
        issue(1'b1, 10'(b * 256 + o), pat(b * 256 + o + 1), last);
        if (o == 0 && b == 0) first = last;
      end
    chk(last - first == 1023, "R3 bank-rotating writes one per clock", last - first, 1023);
    settle();
    t_stream(1, 16, CYC, "R3 unit stride stays in one bank");
    t_stream(256, 4, 1, "R3 stride 256 rotates banks");
  endtask

  task automatic t_mixed();
    logic [15:0] lf = 16'hACE1;
    int t = 0;
    sel = 1'b0;
    issue(1'b0, 10'd100, 8'h00, t);
    issue(1'b1, 10'd100, 8'hC3, t);
    issue(1'b0, 10'd100, 8'h00, t);
    for (int i = 0; i < 200; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      issue(lf[15], lf[9:0] & (lf[0] ? 10'h00F : 10'h3FF), lf[7:0] ^ 8'hA5, t);
    end
    settle();
  endtask

  initial begin
    #(PER * 150000);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_fill_interleaved();
    sel = 1'b0;
    t_stream(1, 1024, 1, "R5 unit stride one word per clock");
    t_stream(4, 16, CYC, "R4 stride 4 one word per bank cycle");
    t_pairs();
    t_block();
    t_mixed();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule